// File: doc/BRIEF.md
# Idle-Delimited Character Packet Assembler

This block sits behind a serial character receiver. It gathers the characters of one packet into a local buffer and hands the finished packet to a consumer. Each 8-bit character carries a frame marker in bit 7 and a 7-bit payload in bits 6:0. The marker is checked and then dropped, and only the payload is stored. Packets arrive as an unbroken run of characters. No length field and no delimiter byte marks where a packet ends: the end is found by timing how long the line stays idle.

The receiver gives one `chr_valid` strobe for each character. It also gives one `idle_tick` pulse for each bit period in which the line is idle. The assembler counts these ticks. More than 20 idle ticks after the last character closes the packet. At that point the assembler raises `pkt_ready` and presents the length and four error flags. The consumer reads payload entries by index through a combinational port and returns the buffer with `rd_release`. The whole packet is captured before it is handed on, so the consumer only works on it while the line is quiet.

Top module: `pkt_assembler`

## Requirements
- R1: After reset `pkt_ready` is 0, `pkt_len` is 0 and all four error flags are 0.
- R2: Entry i of the buffer holds bits 6:0 of the i-th character of the packet (entry 0 is the first character). `rd_payload` shows the entry chosen by `rd_idx` in the same cycle, and bit 7 is never stored.
- R3: The packet is closed on the 21st `idle_tick` after its last character, and `pkt_ready` is high from the next cycle on. Twenty ticks do not close it. A character that arrives during the idle gap restarts the count from zero.
- R4: When a packet is released, `pkt_len` gives its number of stored characters, which is 12 to 24 for a well-formed packet.
- R5: The first character must have bit 7 set, and every later character must have it clear. Any mismatch sets `err_frame` for that packet.
- R6: A packet with fewer than 12 characters is still released with its true length, and `err_short` is set.
- R7: Characters after the 24th are discarded. In that case `err_overflow` is set, `pkt_len` stays 24 and the stored entries are left unchanged.
- R8: When the first character of a new packet arrives while `pkt_ready` is high, `pkt_ready` drops in the next cycle and the buffer is overwritten. That new packet is released with `err_lost` set.
- R9: `rd_release` clears `pkt_ready` in the next cycle. `pkt_len` and the error flags keep their values until the next release.
- R10: `idle_tick` pulses while no packet is being received have no effect: `pkt_ready` and `pkt_len` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is on `chr_data` |
| chr_data | input | 8 | Received character: bit 7 is the frame marker, bits 6:0 the payload |
| idle_tick | input | 1 | One pulse for each bit period in which the line is idle |
| rd_release | input | 1 | Consumer is done with the released packet |
| rd_idx | input | 5 | Index of the payload entry to read |
| pkt_ready | output | 1 | A completed packet is available |
| pkt_len | output | 5 | Number of stored characters in the released packet |
| rd_payload | output | 7 | Payload entry at `rd_idx` |
| err_frame | output | 1 | Released packet had a frame-marker mismatch |
| err_short | output | 1 | Released packet had fewer than 12 characters |
| err_overflow | output | 1 | Released packet had more than 24 characters; the extra ones were dropped |
| err_lost | output | 1 | Released packet overwrote one that was never released |

## Verification
A wrong write pointer or a stored frame bit shows up as a wrong `rd_payload` value at a known index as soon as the packet is released. Each stored entry is compared with the byte that was sent. An idle counter that is off by one opens `pkt_ready` one tick early or one tick late, so `pkt_ready` is sampled after the 20th tick and again after the 21st. Errors in the pending flags stay hidden until the release. For this reason every error case is followed by a clean packet, which shows that each flag clears again.

// File: rtl/pkt_asm_pkg.sv
`timescale 1ns/1ps
package pkt_asm_pkg;
    localparam int unsigned PAYLOAD_W   = 7;
    localparam int unsigned MAX_CHARS   = 24;
    localparam int unsigned MIN_CHARS   = 12;
    localparam int unsigned IDLE_LIMIT  = 20;

    typedef struct packed {
        logic frame;
        logic short_pkt;
        logic overflow;
        logic lost;
    } pkt_flags_t;
endpackage

// File: rtl/pkt_frame_check.sv
`timescale 1ns/1ps
// Splits a character into its marker and payload and judges the marker.
module pkt_frame_check #(
    parameter int unsigned PAYLOAD_W = 7,
    localparam int unsigned CHAR_W  = PAYLOAD_W + 1
) (
    input  logic [CHAR_W-1:0]    chr,
    input  logic                 is_first,
    output logic [PAYLOAD_W-1:0] payload,
    output logic                 mismatch
);
    logic marker;

    always_comb begin
        marker   = chr[CHAR_W-1];
        payload  = chr[PAYLOAD_W-1:0];
        // leading character carries the marker, the rest must not
        mismatch = is_first ? ~marker : marker;
    end
endmodule

// File: rtl/pkt_idle_timer.sv
`timescale 1ns/1ps
// Counts idle bit periods after the last character of an open packet.
module pkt_idle_timer #(
    parameter int unsigned IDLE_LIMIT = 20,
    localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic chr_valid,
    input  logic idle_tick,
    output logic expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (chr_valid || !active) begin
            cnt_d = '0;
        end else if (idle_tick) begin
            if (cnt_q == CNT_W'(IDLE_LIMIT)) begin
                expire = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_char_restarts_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |=> cnt_q == '0);
    p_gap_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(IDLE_LIMIT));
endmodule

// File: rtl/pkt_store.sv
`timescale 1ns/1ps
// Payload buffer: one write port, one combinational read port.
module pkt_store #(
    parameter int unsigned DEPTH  = 24,
    parameter int unsigned WIDTH  = 7,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (waddr == IDX_W'(i))) mem_d[i] = wdata;
        end
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == IDX_W'(i)) rdata = mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr) |=> (rdata == $past(wdata)) || (raddr != $past(raddr)));
endmodule

// File: rtl/pkt_assembler.sv
`timescale 1ns/1ps
module pkt_assembler
    import pkt_asm_pkg::*;
#(
    parameter int unsigned P_W    = PAYLOAD_W,
    parameter int unsigned N_MAX  = MAX_CHARS,
    parameter int unsigned N_MIN  = MIN_CHARS,
    parameter int unsigned GAP    = IDLE_LIMIT,
    localparam int unsigned CHAR_W = P_W + 1,
    localparam int unsigned CNT_W  = $clog2(N_MAX + 1),
    localparam int unsigned IDX_W  = $clog2(N_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [CHAR_W-1:0] chr_data,
    input  logic              idle_tick,
    input  logic              rd_release,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              pkt_ready,
    output logic [CNT_W-1:0]  pkt_len,
    output logic [P_W-1:0]    rd_payload,
    output logic              err_frame,
    output logic              err_short,
    output logic              err_overflow,
    output logic              err_lost
);
    typedef struct packed {
        logic             active;
        logic             ready;
        logic [CNT_W-1:0] cnt;
        pkt_flags_t       pend;
        logic [CNT_W-1:0] len;
        pkt_flags_t       flags;
    } asm_state_t;

    asm_state_t st_d, st_q;

    logic             expire;
    logic [P_W-1:0]   chr_payload;
    logic             chr_mismatch;
    logic             we;
    logic [IDX_W-1:0] waddr;

    pkt_frame_check #(.PAYLOAD_W(P_W)) u_check (
        .chr      (chr_data),
        .is_first (!st_q.active),
        .payload  (chr_payload),
        .mismatch (chr_mismatch)
    );

    pkt_idle_timer #(.IDLE_LIMIT(GAP)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (st_q.active),
        .chr_valid (chr_valid),
        .idle_tick (idle_tick),
        .expire    (expire)
    );

    pkt_store #(.DEPTH(N_MAX), .WIDTH(P_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (chr_payload),
        .raddr (rd_idx),
        .rdata (rd_payload)
    );

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = IDX_W'(st_q.cnt);
        if (chr_valid) begin
            if (!st_q.active) begin
                // opening character: restart buffer, note an unread packet
                st_d.active         = 1'b1;
                st_d.ready          = 1'b0;
                st_d.cnt            = CNT_W'(1);
                st_d.pend.frame     = chr_mismatch;
                st_d.pend.short_pkt = 1'b0;
                st_d.pend.overflow  = 1'b0;
                st_d.pend.lost      = st_q.ready;
                we                  = 1'b1;
                waddr               = '0;
            end else begin
                st_d.pend.frame = st_q.pend.frame | chr_mismatch;
                if (st_q.cnt == CNT_W'(N_MAX)) begin
                    st_d.pend.overflow = 1'b1;
                end else begin
                    we       = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else if (expire) begin
            st_d.active          = 1'b0;
            st_d.ready           = 1'b1;
            st_d.len             = st_q.cnt;
            st_d.flags           = st_q.pend;
            st_d.flags.short_pkt = (st_q.cnt < CNT_W'(N_MIN));
        end else if (rd_release) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pkt_ready    = st_q.ready;
        pkt_len      = st_q.len;
        err_frame    = st_q.flags.frame;
        err_short    = st_q.flags.short_pkt;
        err_overflow = st_q.flags.overflow;
        err_lost     = st_q.flags.lost;
    end

    p_ready_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_ready) |-> $past(expire));
    p_len_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (pkt_len >= CNT_W'(1)) && (pkt_len <= CNT_W'(N_MAX)));
    p_short_matches_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (err_short == (pkt_len < CNT_W'(N_MIN))));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(N_MAX));
    p_full_discards_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && chr_valid && st_q.cnt == CNT_W'(N_MAX)) |=> st_q.cnt == CNT_W'(N_MAX));
    p_restart_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && chr_valid) |=> (!pkt_ready && st_q.pend.lost));
    p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && rd_release && !chr_valid) |=> !pkt_ready && $stable(pkt_len));
    p_idle_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !chr_valid && !rd_release) |=> $stable(pkt_ready) && $stable(pkt_len));
endmodule

// File: tb/tb_pkt_assembler.sv
`timescale 1ns/1ps
module tb_pkt_assembler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_valid = 1'b0;
    logic [7:0] chr_data = '0;
    logic       idle_tick = 1'b0;
    logic       rd_release = 1'b0;
    logic [4:0] rd_idx = '0;
    logic       pkt_ready;
    logic [4:0] pkt_len;
    logic [6:0] rd_payload;
    logic       err_frame, err_short, err_overflow, err_lost;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    pkt_assembler dut (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .idle_tick(idle_tick), .rd_release(rd_release), .rd_idx(rd_idx),
        .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rd_payload(rd_payload),
        .err_frame(err_frame), .err_short(err_short),
        .err_overflow(err_overflow), .err_lost(err_lost)
    );

    function automatic logic [6:0] pay(int seed, int i);
        return 7'((seed * 13 + i * 37 + 5) & 8'h7f);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all drives happen at the falling edge
    task automatic send(logic marker, logic [6:0] p);
        chr_valid = 1'b1;
        chr_data  = {marker, p};
        @(negedge clk);
        chr_valid = 1'b0;
    endtask

    task automatic send_packet(int seed, int n, int bad_idx);
        for (int i = 0; i < n; i++) begin
            logic m;
            m = (i == 0);
            if (i == bad_idx) m = ~m;
            send(m, pay(seed, i));
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            idle_tick = 1'b1;
            @(negedge clk);
        end
        idle_tick = 1'b0;
    endtask

    task automatic release_pkt();
        rd_release = 1'b1;
        @(negedge clk);
        rd_release = 1'b0;
        chk("R9 ready cleared by release", int'(pkt_ready), 0);
    endtask

    task automatic check_payload(string req, int seed, int n);
        for (int i = 0; i < n; i++) begin
            rd_idx = 5'(i);
            #1;
            chk(req, int'(rd_payload), int'(pay(seed, i)));
        end
    endtask

    task automatic check_flags(string req, int f, int s, int o, int l);
        chk({req, " err_frame"}, int'(err_frame), f);
        chk({req, " err_short"}, int'(err_short), s);
        chk({req, " err_overflow"}, int'(err_overflow), o);
        chk({req, " err_lost"}, int'(err_lost), l);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", int'(pkt_ready), 0);
        chk("R1 len after reset", int'(pkt_len), 0);
        check_flags("R1", 0, 0, 0, 0);
    endtask

    task automatic t_idle_ignored();
        ticks(30);
        chk("R10 idle ticks without packet: ready", int'(pkt_ready), 0);
        chk("R10 idle ticks without packet: len", int'(pkt_len), 0);
    endtask

    task automatic t_basic();
        send_packet(1, 12, -1);
        ticks(20);
        chk("R3 twenty ticks do not close packet", int'(pkt_ready), 0);
        ticks(1);
        chk("R3 21st tick closes packet", int'(pkt_ready), 1);
        chk("R4 length of 12-char packet", int'(pkt_len), 12);
        check_flags("R5 clean packet", 0, 0, 0, 0);
        check_payload("R2 payload of 12-char packet", 1, 12);
        ticks(25);
        chk("R10 idle after release keeps ready", int'(pkt_ready), 1);
        chk("R10 idle after release keeps len", int'(pkt_len), 12);
        release_pkt();
        chk("R9 len held after release", int'(pkt_len), 12);
    endtask

    task automatic t_gap_restart();
        send_packet(2, 6, -1);
        ticks(15);
        send_packet(99, 0, -1);
        for (int i = 6; i < 14; i++) send(1'b0, pay(2, i));
        ticks(20);
        chk("R3 char in gap restarts count", int'(pkt_ready), 0);
        ticks(1);
        chk("R3 ready after restarted gap", int'(pkt_ready), 1);
        chk("R4 length 14", int'(pkt_len), 14);
        check_payload("R2 payload across gap", 2, 14);
        release_pkt();
    endtask

    task automatic t_full();
        send_packet(3, 24, -1);
        ticks(21);
        chk("R4 length 24", int'(pkt_len), 24);
        check_flags("R7 full packet no overflow", 0, 0, 0, 0);
        check_payload("R2 payload of 24-char packet", 3, 24);
        release_pkt();
    endtask

    task automatic t_frame();
        send_packet(4, 13, 5);
        ticks(21);
        check_flags("R5 marker on later char", 1, 0, 0, 0);
        check_payload("R2 marker bit not stored", 4, 13);
        release_pkt();
        send_packet(5, 12, 0);
        ticks(21);
        check_flags("R5 missing leading marker", 1, 0, 0, 0);
        release_pkt();
    endtask

    task automatic t_short();
        send_packet(6, 5, -1);
        ticks(21);
        chk("R6 short packet released", int'(pkt_ready), 1);
        chk("R6 short packet length", int'(pkt_len), 5);
        check_flags("R6 short packet", 0, 1, 0, 0);
        release_pkt();
        send_packet(7, 12, -1);
        ticks(21);
        check_flags("R6 short flag clears", 0, 0, 0, 0);
        release_pkt();
    endtask

    task automatic t_overflow();
        send_packet(8, 24, -1);
        send(1'b0, 7'h00);
        send(1'b0, 7'h7f);
        ticks(21);
        chk("R7 overflow length stays 24", int'(pkt_len), 24);
        check_flags("R7 overflow", 0, 0, 1, 0);
        check_payload("R7 entries untouched by extra chars", 8, 24);
        release_pkt();
    endtask

    task automatic t_lost();
        send_packet(9, 12, -1);
        ticks(21);
        chk("R8 first packet ready", int'(pkt_ready), 1);
        send(1'b1, pay(10, 0));
        chk("R8 ready drops on new start", int'(pkt_ready), 0);
        for (int i = 1; i < 12; i++) send(1'b0, pay(10, i));
        ticks(21);
        check_flags("R8 lost packet", 0, 0, 0, 1);
        check_payload("R8 buffer overwritten", 10, 12);
        release_pkt();
        send_packet(11, 12, -1);
        ticks(21);
        check_flags("R8 lost flag clears", 0, 0, 0, 0);
        release_pkt();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_basic();
        t_gap_restart();
        t_full();
        t_frame();
        t_short();
        t_overflow();
        t_lost();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule